// File: doc/BRIEF.md
# Resonant-Mode Complementary PWM Generator

This block drives the two switches of a half-bridge resonant stage. A free-running period counter, running on the base clock, produces a high-side drive A and a low-side drive B. Both are set apart by one programmable dead time. The switching period changes at run time, which is the frequency control of the converter.

The A on-time is the product of a control-loop output word, taken as an unsigned fraction, and a 14-bit resonant-duty word. This product is clamped so that neither pulse can become negative in width. Period, dead time, sample-trigger compare, loop output and resonant duty are all shadowed. The block takes up new values only at the end of a period.

A cycle-by-cycle fault input can cut a pulse short. A pulse-matching option makes B copy the width that A actually delivered. A one-cycle sample-trigger pulse marks a programmable point of each period, for use by the acquisition path.

Top module: `rpwm_gen`

## Requirements
- R1: While `en_i` is low, `a_o`, `b_o` and `strig_o` are low on the cycle after, and the counter rests at zero. After `en_i` rises, a fresh period starts at count 0, so A first rises dt+1 cycles after the first enabled clock edge.
- R2: The period, dead-time and trigger words each carry 4 fractional low bits. Only the integer part (word >> 4, in base clock cycles) is used for edge placement. A change in the fractional bits leaves every output unchanged.
- R3: The on-time D is the raw product, clamped. The raw product is (loop_i * rduty_i) >> 16. The clamp keeps D within 2*dt and P - 2*dt.
- R4: Within a period of P cycles, A is high for counts dt to D-1 and B is high for counts D+dt to P-dt-1. So A is high for D-dt cycles, B rises D cycles after A rises, and B is high for P-D-2*dt cycles.
- R5: A and B are never high together. With dt = 0, B rises in the same cycle that A falls.
- R6: Period, dead time, trigger, loop output and resonant duty written during a period do not affect that period. They take effect from the next period.
- R7: With `cbc_en_i` high, a fault seen while A is high drops A at the next edge, and A stays low for the rest of the period. With `cbc_en_i` low, the fault has no effect.
- R8: A fault while B is high cuts B in the same way only when `fault_both_i` is high. Otherwise B is unaffected.
- R9: With `match_i` high, B is high for no more cycles than A was in the same period. With `match_i` low, B keeps its full width.
- R10: `strig_o` pulses for one cycle each period, trig-dt cycles after A rises (modulo P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Local enable |
| period_i | input | 20 | Period word, 4 fractional bits |
| dead_i | input | 20 | Dead-time word, 4 fractional bits |
| trig_i | input | 20 | Sample-trigger compare word, 4 fractional bits |
| loop_i | input | 16 | Control-loop output, unsigned fraction |
| rduty_i | input | 14 | Resonant-duty multiplier in clock cycles |
| fault_i | input | 1 | Cycle-by-cycle fault |
| cbc_en_i | input | 1 | Enables fault truncation |
| fault_both_i | input | 1 | Fault also acts while B is high |
| match_i | input | 1 | B width matches delivered A width |
| a_o | output | 1 | High-side drive |
| b_o | output | 1 | Low-side drive |
| strig_o | output | 1 | Sample-trigger pulse |

## Verification
Some properties are checked on every cycle: the drives never overlap, outputs fall after a disable, the counter stays below the period, and shadow values hold between period ends. The clamped on-time must lie within its bounds, a hit drive stays off, and under matching B never exceeds the A count. Other behaviour only the bench's scenarios can show. This covers pulse widths and the B start offset for several period, dead-time and gain mixes, including the zero dead-time and both clamp limits. It also covers that fractional bits have no effect, that a write in mid-period applies on the following period, the exact truncated widths in each fault mode, and the position of the trigger.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
  localparam int FRAC_W = 4;   // fractional bits on time words
  localparam int LOOP_W = 16;  // loop output is an unsigned fraction of this width
  localparam int RD_W   = 14;  // resonant-duty multiplier width
endpackage

// File: rtl/rpwm_ontime.sv
module rpwm_ontime #(
  parameter int CNT_W  = 16,
  parameter int LOOP_W = 16,
  parameter int RD_W   = 14
) (
  input  logic [CNT_W-1:0]  per_i,
  input  logic [CNT_W-1:0]  dt_i,
  input  logic [LOOP_W-1:0] loop_i,
  input  logic [RD_W-1:0]   rduty_i,
  output logic [CNT_W-1:0]  d_o
);
  localparam int PROD_W = LOOP_W + RD_W;
  localparam int W      = CNT_W + 2;

  logic [PROD_W-1:0] prod;
  logic [W-1:0]      raw, lo, hi, clip;
  logic signed [W:0] hi_s;

  always_comb begin
    prod = PROD_W'(loop_i) * PROD_W'(rduty_i);
    raw  = W'(prod >> LOOP_W);
    lo   = W'(dt_i) << 1;
    hi_s = $signed({1'b0, W'(per_i)}) - $signed({1'b0, lo});
    hi   = hi_s[W] ? '0 : hi_s[W-1:0];
    clip = (raw > hi) ? hi : raw;
    if (clip < lo) clip = lo;
    d_o  = clip[CNT_W-1:0];
  end
endmodule

// File: rtl/rpwm_timebase.sv
module rpwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_n_i,
  input  logic [CNT_W-1:0] dt_n_i,
  input  logic [CNT_W-1:0] trig_n_i,
  input  logic [CNT_W-1:0] d_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] dt_o,
  output logic [CNT_W-1:0] trig_o,
  output logic [CNT_W-1:0] d_o,
  output logic             clr_o
);
  logic [CNT_W-1:0] cnt_q, per_q, dt_q, trig_q, d_q;
  logic [CNT_W:0]   cnt_nx;
  logic             wrap, load;

  always_comb begin
    cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap   = cnt_nx >= {1'b0, per_q};
    load   = !en_i || wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      dt_q   <= '0;
      trig_q <= '0;
      d_q    <= '0;
    end else begin
      cnt_q <= load ? '0 : cnt_nx[CNT_W-1:0];
      if (load) begin  // shadow copy only at period end or while idle
        per_q  <= per_n_i;
        dt_q   <= dt_n_i;
        trig_q <= trig_n_i;
        d_q    <= d_n_i;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign dt_o   = dt_q;
  assign trig_o = trig_q;
  assign d_o    = d_q;
  assign clr_o  = load;

  logic [CNT_W+2:0] dt2_x, dt4_x, per_x, d_x;
  assign dt2_x = {3'b0, dt_q} << 1;
  assign dt4_x = {3'b0, dt_q} << 2;
  assign per_x = {3'b0, per_q};
  assign d_x   = {3'b0, d_q};

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && per_q != '0) |-> cnt_q < per_q);  // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap) |=> ($stable(per_q) && $stable(d_q) && $stable(dt_q)));  // R6
  AST_ONTIME_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_x >= dt4_x) |-> (d_x >= dt2_x && d_x <= per_x - dt2_x));  // R3
endmodule

// File: rtl/rpwm_drive.sv
module rpwm_drive #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dt_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic [CNT_W-1:0] d_i,
  input  logic             fault_i,
  input  logic             cbc_en_i,
  input  logic             fault_both_i,
  input  logic             match_i,
  output logic             a_o,
  output logic             b_o,
  output logic             strig_o
);
  localparam int XW = CNT_W + 1;

  logic          a_q, b_q, st_q, kill_a, kill_b;
  logic [XW-1:0] a_w, b_w, b_start, b_stop, cnt_x;
  logic          a_win, b_win, hit_a, hit_b, a_nx, b_nx, st_nx;

  always_comb begin
    cnt_x   = {1'b0, cnt_i};
    b_start = {1'b0, d_i} + {1'b0, dt_i};
    b_stop  = (per_i >= dt_i) ? {1'b0, per_i - dt_i} : '0;
    a_win   = (cnt_i >= dt_i) && (cnt_i < d_i);
    b_win   = (cnt_x >= b_start) && (cnt_x < b_stop);
    hit_a   = cbc_en_i && fault_i && a_q;
    hit_b   = cbc_en_i && fault_both_i && fault_i && b_q;
    a_nx    = en_i && a_win && !kill_a && !hit_a;
    b_nx    = en_i && b_win && !kill_b && !hit_b && (!match_i || (b_w < a_w));
    st_nx   = en_i && (cnt_i == trig_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      st_q   <= 1'b0;
      kill_a <= 1'b0;
      kill_b <= 1'b0;
      a_w    <= '0;
      b_w    <= '0;
    end else begin
      a_q  <= a_nx;
      b_q  <= b_nx;
      st_q <= st_nx;
      if (clr_i) begin
        kill_a <= 1'b0;
        kill_b <= 1'b0;
        a_w    <= '0;
        b_w    <= '0;
      end else begin
        kill_a <= kill_a || hit_a;
        kill_b <= kill_b || hit_b;
        a_w    <= a_w + XW'(a_nx);
        b_w    <= b_w + XW'(b_nx);
      end
    end
  end

  assign a_o     = a_q;
  assign b_o     = b_q;
  assign strig_o = st_q;

  AST_OFF_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!a_q && !b_q && !st_q));  // R1
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_q && b_q));  // R5
  AST_A_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a && !clr_i) |=> !a_q);  // R7
  AST_B_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_b && !clr_i) |=> !b_q);  // R8
  AST_MATCH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && b_q) |-> (b_w <= a_w));  // R9
  AST_TRIG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i > 1 && st_q) |=> !st_q);  // R10
endmodule

// File: rtl/rpwm_gen.sv
module rpwm_gen #(
  parameter int PER_W  = 20,
  parameter int FRAC_W = rpwm_pkg::FRAC_W,
  parameter int LOOP_W = rpwm_pkg::LOOP_W,
  parameter int RD_W   = rpwm_pkg::RD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [PER_W-1:0]  dead_i,
  input  logic [PER_W-1:0]  trig_i,
  input  logic [LOOP_W-1:0] loop_i,
  input  logic [RD_W-1:0]   rduty_i,
  input  logic              fault_i,
  input  logic              cbc_en_i,
  input  logic              fault_both_i,
  input  logic              match_i,
  output logic              a_o,
  output logic              b_o,
  output logic              strig_o
);
  localparam int CNT_W = PER_W - FRAC_W;

  logic [CNT_W-1:0] per_n, dt_n, trig_n, d_n;
  logic [CNT_W-1:0] cnt, per_s, dt_s, trig_s, d_s;
  logic             clr;
  logic             unused_frac;

  // coarse compare uses integer part only; fraction is left for a fine delay stage
  assign per_n       = period_i[PER_W-1:FRAC_W];
  assign dt_n        = dead_i[PER_W-1:FRAC_W];
  assign trig_n      = trig_i[PER_W-1:FRAC_W];
  assign unused_frac = ^{period_i[FRAC_W-1:0], dead_i[FRAC_W-1:0], trig_i[FRAC_W-1:0]};

  rpwm_ontime #(.CNT_W(CNT_W), .LOOP_W(LOOP_W), .RD_W(RD_W)) u_ontime (
    .per_i  (per_n),
    .dt_i   (dt_n),
    .loop_i (loop_i),
    .rduty_i(rduty_i),
    .d_o    (d_n)
  );

  rpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .per_n_i (per_n),
    .dt_n_i  (dt_n),
    .trig_n_i(trig_n),
    .d_n_i   (d_n),
    .cnt_o   (cnt),
    .per_o   (per_s),
    .dt_o    (dt_s),
    .trig_o  (trig_s),
    .d_o     (d_s),
    .clr_o   (clr)
  );

  rpwm_drive #(.CNT_W(CNT_W)) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .clr_i       (clr),
    .cnt_i       (cnt),
    .per_i       (per_s),
    .dt_i        (dt_s),
    .trig_i      (trig_s),
    .d_i         (d_s),
    .fault_i     (fault_i),
    .cbc_en_i    (cbc_en_i),
    .fault_both_i(fault_both_i),
    .match_i     (match_i),
    .a_o         (a_o),
    .b_o         (b_o),
    .strig_o     (strig_o)
  );
endmodule

// File: tb/tb_rpwm_gen.sv
module tb_rpwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PER_W = 20;
  localparam int NV = 6;
  // columns: period, dead, loop, rduty, trig, fractional bits
  localparam int VEC [NV][6] = '{
    '{40, 4, 32'h8000, 20, 10, 0},
    '{40, 0, 32'hFFFF, 20,  0, 0},
    '{50, 5, 32'h1000, 20,  7, 0},
    '{32, 3, 32'hFFFF, 100, 20, 0},
    '{40, 4, 32'h8000, 20, 10, 15},
    '{64, 2, 32'h4000, 100, 28, 0}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [PER_W-1:0] period_w = '0, dead_w = '0, trig_w = '0;
  logic [15:0] loop_w = '0;
  logic [13:0] rduty_w = '0;
  logic fault = 1'b0, cbc_en = 1'b0, fault_both = 1'b0, match = 1'b0;
  logic a, b, st;

  int total = 0, bad = 0;
  int m_a, m_b, m_bs, m_ov, m_sc, m_si;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpwm_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period_w), .dead_i(dead_w),
    .trig_i(trig_w), .loop_i(loop_w), .rduty_i(rduty_w), .fault_i(fault),
    .cbc_en_i(cbc_en), .fault_both_i(fault_both), .match_i(match),
    .a_o(a), .b_o(b), .strig_o(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_d(input int p, input int dt, input int lp, input int rd);
    int d;
    d = (lp * rd) >>> 16;
    if (d > p - 2*dt) d = p - 2*dt;
    if (d < 2*dt) d = 2*dt;
    return d;
  endfunction

  task automatic cfg(input int p, input int dt, input int lp, input int rd, input int tr, input int fr);
    period_w = PER_W'((p << 4) | fr);
    dead_w   = PER_W'((dt << 4) | fr);
    trig_w   = PER_W'((tr << 4) | (fr & 9));
    loop_w   = 16'(lp);
    rduty_w  = 14'(rd);
  endtask

  // align to an A rise, then sample n cycles; optional one-cycle fault and input swap
  task automatic measure(input int n, input int fidx, input bit swap);
    int prev, guard;
    prev = a; guard = 0;
    forever begin
      @(negedge clk);
      if (a && !prev) break;
      prev = a;
      guard++;
      if (guard > 2000) break;
    end
    m_a = 0; m_b = 0; m_bs = -1; m_ov = 0; m_sc = 0; m_si = -1;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (a) m_a++;
      if (b) begin m_b++; if (m_bs < 0) m_bs = i; end
      if (a && b) m_ov++;
      if (st) begin m_sc++; if (m_si < 0) m_si = i; end
      fault = (i == fidx);
      if (swap && i == 2) cfg(VEC[5][0], VEC[5][1], VEC[5][2], VEC[5][3], VEC[5][4], 0);
    end
    fault = 1'b0;
  endtask

  task automatic restart();
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset a_o", int'(a), 0);
    chk("R1 reset b_o", int'(b), 0);
    chk("R1 reset strig_o", int'(st), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: widths, B start, overlap, trigger (R2 R3 R4 R5 R10)
    for (int v = 0; v < NV; v++) begin
      int p, dt, d, ea, eb, si;
      p = VEC[v][0]; dt = VEC[v][1];
      d = exp_d(p, dt, VEC[v][2], VEC[v][3]);
      ea = d - dt; eb = p - d - 2*dt;
      si = ((VEC[v][4] - dt) % p + p) % p;
      cfg(p, dt, VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      restart();
      measure(p, -1, 0);
      chk($sformatf("R3 R4 vec%0d A width", v), m_a, ea);
      chk($sformatf("R4 vec%0d B width", v), m_b, eb);
      if (eb > 0) chk($sformatf("R4 R5 vec%0d B start", v), m_bs, d);
      chk($sformatf("R5 vec%0d overlap", v), m_ov, 0);
      chk($sformatf("R10 vec%0d trig count", v), m_sc, 1);
      chk($sformatf("R10 vec%0d trig index", v), m_si, si);
      if (VEC[v][5] != 0) chk("R2 fraction ignored A", m_a, 6);
    end
    // zero dead time: B rises right as A falls
    cfg(40, 0, 32'hFFFF, 20, 0, 0); restart(); measure(40, -1, 0);
    chk("R5 zero dt B start equals A width", m_bs, m_a);

    // R6: mid-period write applies next period
    cfg(40, 4, 32'h8000, 20, 10, 0); restart();
    measure(36, -1, 1);
    chk("R6 old period A", m_a, 6);
    chk("R6 old period B", m_b, 22);
    measure(64, -1, 0);
    chk("R6 new period A", m_a, 23);
    chk("R6 new period B", m_b, 35);

    // faults: P40 dt4 D20 -> A16 B12
    cbc_en = 1; fault_both = 0; match = 0;
    cfg(40, 4, 32'h8000, 40, 10, 0); restart(); measure(40, 4, 0);
    chk("R7 A cut", m_a, 5);
    chk("R9 B independent", m_b, 12);
    en = 0; match = 1; restart(); measure(40, 4, 0);
    chk("R9 B matched", m_b, 5);
    en = 0; match = 1; restart(); measure(40, -1, 0);
    chk("R9 B match no fault", m_b, 12);
    en = 0; match = 0; fault_both = 0; restart(); measure(40, 22, 0);
    chk("R8 B fault ignored", m_b, 12);
    en = 0; fault_both = 1; restart(); measure(40, 22, 0);
    chk("R8 B cut", m_b, 3);
    en = 0; cbc_en = 0; fault_both = 0; restart(); measure(40, 4, 0);
    chk("R7 fault ignored when off", m_a, 16);

    // R1: disable holds outputs low, restart from a fresh period
    cfg(40, 4, 32'h8000, 20, 10, 0);
    en = 0;
    repeat (2) @(negedge clk);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (a || b || st) hi++;
      end
      chk("R1 idle outputs low", hi, 0);
    end
    en = 1;
    begin
      int n;
      n = 0;
      while (!a && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk("R1 first A rise after enable", n, 5);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule